// File: doc/BRIEF.md
# I2C High-Speed Mode Entry Controller

This target-side block watches the two wires of an I2C bus, oversamples them with the system clock, and decides when the bus has moved into high-speed operation. After a START taken from an idle bus, it shifts in the first byte. If the upper five bits of that byte form the high-speed master code, the block raises a mode flag. The surrounding chip uses that flag to choose its glitch filter and timing set. The block never acknowledges the master code. Repeated starts keep the mode, and only a STOP drops it.

Alongside the mode flag, the block reports bus conditions as single-cycle strobes: a start from idle, a repeated start, and a stop. It also drives an SDA pull-low enable during the acknowledge clock. That enable is used only for the general-call reset sequence. It returns the block to its power-up state, as does a software reset input.

Top module: `i2c_hs_entry`

## Requirements
- R1: An SDA fall while SCL is high, seen when the block is idle, gives exactly one `start_pulse` and no other strobe.
- R2: The same condition seen while a transfer is open gives one `rstart_pulse` and no `start_pulse`.
- R3: An SDA rise while SCL is high gives one `stop_pulse`.
- R4: When the first byte after an idle START (sent MSB first) has bits 7..3 equal to 00001, `hs_mode` is high once the ninth SCL clock has ended. Bits 2..0 of that byte can take any value. Any other first byte, such as 0x10, leaves `hs_mode` low.
- R5: During the ninth clock of a master-code byte, `sda_pull` stays low, so the bus reads a not-acknowledge.
- R6: `hs_mode` stays high across repeated starts and across the bytes that follow them.
- R7: A STOP clears `hs_mode` in the same cycle that `stop_pulse` is raised.
- R8: The master-code pattern is ignored, with no acknowledge, in two cases: when it arrives as the second or a later byte of a transfer, and when it arrives as the first byte after a repeated start.
- R9: A first byte of 0x00 after any start is acknowledged. If the next byte is 0x06, that byte is acknowledged too, and when its ninth clock ends `hs_mode` is cleared and the block returns to idle. Any other second byte is not acknowledged.
- R10: A one-cycle pulse on `sw_rst` clears `hs_mode` by the next cycle.
- R11: While `rst` is high and afterwards, `hs_mode`, `sda_pull` and all strobes are low until bus activity occurs.
- R12: `hs_mode` rises only in the cycle after the ninth SCL clock ends, never in the middle of a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst | input | 1 | Software reset request; returns the block to its power-up state |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| hs_mode | output | 1 | High while the bus is in high-speed mode |
| start_pulse | output | 1 | One-cycle strobe for a START from idle |
| rstart_pulse | output | 1 | One-cycle strobe for a repeated START |
| stop_pulse | output | 1 | One-cycle strobe for a STOP |
| sda_pull | output | 1 | Pull SDA low (acknowledge drive) |

## Verification
The bench aims at the master-code variants. It sends 0x08 and 0x0F, which both match, and 0x10, which does not. A design that compared all eight bits, or the wrong five bits, would miss the 0x0F entry or would enter high-speed mode on 0x10.

The bench also puts the pattern where it must not count: after a repeated start, and as the second byte of a transfer. A design that did not track the first byte after an idle START would enter high-speed mode wrongly in those cases.

Several checks target the mode's lifetime. High-speed mode must survive two repeated starts and end on a STOP. A design that cleared the flag on any start, or kept it after a STOP, would be caught there.

Finally, the bench samples the bus during each ninth clock. It expects the master code to be not-acknowledged and the general-call bytes to be acknowledged. It checks that the 0x00/0x06 sequence and the software reset both drop the mode.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;
  // Transfer-phase tracking for the entry controller.
  typedef enum logic [2:0] {
    ST_IDLE,   // no transfer open
    ST_FIRST,  // first byte after a START from idle
    ST_ADDR,   // first byte after a repeated START
    ST_GCCMD,  // command byte following a general call
    ST_SKIP    // remaining bytes, ignored
  } hs_state_e;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);
  logic [LANES-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic sda,
  input  logic scl,
  output logic start_c,
  output logic stop_c,
  output logic scl_rise,
  output logic scl_fall
);
  logic sda_q, scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda;
      scl_q <= scl;
    end
  end

  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;
  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda,
  output logic [BYTE_W-1:0] byte_q,
  output logic              ack_open,
  output logic              ack_close
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  logic [CNT_W-1:0] cnt;
  logic             ninth;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt    <= '0;
      ninth  <= 1'b0;
      byte_q <= '0;
    end else if (scl_rise) begin
      if (cnt != LAST) begin
        byte_q <= {byte_q[BYTE_W-2:0], sda};
        cnt    <= cnt + 1'b1;
      end else begin
        ninth <= 1'b1;
      end
    end else if (scl_fall && ninth) begin
      cnt   <= '0;
      ninth <= 1'b0;
    end
  end

  assign ack_open  = scl_fall && (cnt == LAST) && !ninth;
  assign ack_close = scl_fall && ninth;
endmodule

// File: rtl/i2c_hs_entry.sv
module i2c_hs_entry #(
  parameter int                  SYNC_STAGES  = 2,
  parameter int                  BYTE_W       = 8,
  parameter int                  PREFIX_W     = 5,
  parameter logic [PREFIX_W-1:0] MCODE_PREFIX = 5'b00001,
  parameter logic [BYTE_W-1:0]   GC_RST_CMD   = 8'h06
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_rst,
  input  logic sda_in,
  input  logic scl_in,
  output logic hs_mode,
  output logic start_pulse,
  output logic rstart_pulse,
  output logic stop_pulse,
  output logic sda_pull
);
  import i2c_hs_pkg::*;

  logic [1:0]        bus_s;
  logic              start_c, stop_c, scl_rise, scl_fall;
  logic [BYTE_W-1:0] rx_byte;
  logic              ack_open, ack_close;
  hs_state_e         state;
  logic              mcode_pend, gc_pend;
  logic              mc_hit, gc_addr, gc_cmd;

  i2c_sync #(.LANES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({sda_in, scl_in}), .q(bus_s)
  );

  i2c_cond_det u_cond (
    .clk(clk), .rst(rst), .sda(bus_s[1]), .scl(bus_s[0]),
    .start_c(start_c), .stop_c(stop_c),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2c_byte_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .clr(start_c | stop_c),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda(bus_s[1]),
    .byte_q(rx_byte), .ack_open(ack_open), .ack_close(ack_close)
  );

  // Byte classification, valid when ack_open fires.
  always_comb begin
    mc_hit  = (state == ST_FIRST) &&
              (rx_byte[BYTE_W-1 -: PREFIX_W] == MCODE_PREFIX);
    gc_addr = ((state == ST_FIRST) || (state == ST_ADDR)) && (rx_byte == '0);
    gc_cmd  = (state == ST_GCCMD) && (rx_byte == GC_RST_CMD);
  end

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      state        <= ST_IDLE;
      hs_mode      <= 1'b0;
      start_pulse  <= 1'b0;
      rstart_pulse <= 1'b0;
      stop_pulse   <= 1'b0;
      sda_pull     <= 1'b0;
      mcode_pend   <= 1'b0;
      gc_pend      <= 1'b0;
    end else begin
      start_pulse  <= 1'b0;
      rstart_pulse <= 1'b0;
      stop_pulse   <= 1'b0;
      if (start_c) begin
        if (state == ST_IDLE) begin
          start_pulse <= 1'b1;
          state       <= ST_FIRST;
        end else begin
          rstart_pulse <= 1'b1;
          state        <= ST_ADDR;
        end
        sda_pull   <= 1'b0;
        mcode_pend <= 1'b0;
        gc_pend    <= 1'b0;
      end else if (stop_c) begin
        stop_pulse <= 1'b1;
        hs_mode    <= 1'b0;
        state      <= ST_IDLE;
        sda_pull   <= 1'b0;
        mcode_pend <= 1'b0;
        gc_pend    <= 1'b0;
      end else if (ack_open && state != ST_IDLE) begin
        mcode_pend <= mc_hit;
        gc_pend    <= gc_cmd;
        sda_pull   <= gc_addr | gc_cmd;
        if (gc_addr)     state <= ST_GCCMD;
        else if (gc_cmd) state <= ST_IDLE;
        else             state <= ST_SKIP;
      end else if (ack_close) begin
        sda_pull   <= 1'b0;
        mcode_pend <= 1'b0;
        gc_pend    <= 1'b0;
        if (gc_pend)         hs_mode <= 1'b0;
        else if (mcode_pend) hs_mode <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_hs_entry_chk.sv
module i2c_hs_entry_chk (
  input logic clk,
  input logic rst,
  input logic sw_rst,
  input logic hs_mode,
  input logic sda_pull,
  input logic start_pulse,
  input logic rstart_pulse,
  input logic stop_pulse,
  input logic mcode_pend,
  input logic ack_close
);
  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !hs_mode && !sda_pull && !start_pulse && !rstart_pulse && !stop_pulse);

  // R1 R2 R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_pulse, rstart_pulse, stop_pulse}));

  // R5
  mcode_nack_chk: assert property (@(posedge clk) disable iff (rst)
    mcode_pend |-> !sda_pull);

  // R6
  rstart_keep_chk: assert property (@(posedge clk) disable iff (rst || sw_rst)
    rstart_pulse && $past(hs_mode) |-> hs_mode);

  // R7
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> !hs_mode);

  // R10
  swrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> !hs_mode);

  // R12
  hs_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_mode) |-> $past(ack_close));
endmodule

bind i2c_hs_entry i2c_hs_entry_chk u_chk (
  .clk(clk), .rst(rst), .sw_rst(sw_rst), .hs_mode(hs_mode),
  .sda_pull(sda_pull), .start_pulse(start_pulse),
  .rstart_pulse(rstart_pulse), .stop_pulse(stop_pulse),
  .mcode_pend(mcode_pend), .ack_close(ack_close)
);

// File: tb/i2c_hs_entry_test.sv
module i2c_hs_entry_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_rst = 1'b0;
  logic sda_drv = 1'b1;
  logic scl_drv = 1'b1;
  logic hs_mode, start_pulse, rstart_pulse, stop_pulse, sda_pull;
  logic sda_bus;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = sda_drv & ~sda_pull;

  i2c_hs_entry uut (
    .clk(clk), .rst(rst), .sw_rst(sw_rst),
    .sda_in(sda_bus), .scl_in(scl_drv),
    .hs_mode(hs_mode), .start_pulse(start_pulse),
    .rstart_pulse(rstart_pulse), .stop_pulse(stop_pulse),
    .sda_pull(sda_pull)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  // Scoreboard monitor: 1=start, 2=repeated start, 3=stop
  always @(negedge clk) begin
    if (!rst && (start_pulse || rstart_pulse || stop_pulse)) begin
      int code;
      int want;
      code = stop_pulse ? 3 : (rstart_pulse ? 2 : 1);
      if ((start_pulse + rstart_pulse + stop_pulse) > 1) code = 9;
      want = (exp_q.size() > 0) ? exp_q.pop_front() : 0;
      check(want == 1 ? "R1" : (want == 2 ? "R2" : "R3"), code, want);
    end
  end

  task automatic bus_start(input int code);
    exp_q.push_back(code);
    sda_drv = 1'b1; wq(1);
    scl_drv = 1'b1; wq(1);
    sda_drv = 1'b0; wq(1);
    scl_drv = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    exp_q.push_back(3);
    sda_drv = 1'b0; wq(1);
    scl_drv = 1'b1; wq(1);
    sda_drv = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wq(1);
      scl_drv = 1'b1; wq(1);
      scl_drv = 1'b0; wq(1);
    end
    sda_drv = 1'b1; wq(1);
    scl_drv = 1'b1;
    repeat (Q / 2) @(negedge clk);
    acked = !sda_bus;
    repeat (Q - Q / 2) @(negedge clk);
    scl_drv = 1'b0; wq(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ak;
    repeat (5) @(negedge clk);
    // R11 reset state
    check("R11 hs_mode", hs_mode, 0);
    check("R11 sda_pull", sda_pull, 0);
    check("R11 strobes", start_pulse | rstart_pulse | stop_pulse, 0);
    rst = 1'b0;
    wq(2);

    // R4 R5 master code 0x08 from idle, then R6 repeated starts
    bus_start(1);
    send_byte(8'h08, ak);
    check("R5 mcode nack", ak, 0);
    check("R4 hs set 0x08", hs_mode, 1);
    bus_start(2);
    check("R6 hs after rstart", hs_mode, 1);
    send_byte(8'hA4, ak);
    check("R6 hs after hs byte", hs_mode, 1);
    send_byte(8'h09, ak);
    check("R8 later byte nack", ak, 0);
    bus_start(2);
    check("R6 hs after 2nd rstart", hs_mode, 1);
    bus_stop();
    check("R7 stop clears", hs_mode, 0);

    // R4 don't-care low bits, and a non-matching byte
    bus_start(1);
    send_byte(8'h0F, ak);
    check("R4 hs set 0x0F", hs_mode, 1);
    check("R5 mcode nack 0x0F", ak, 0);
    bus_stop();
    check("R7 stop clears 2", hs_mode, 0);
    bus_start(1);
    send_byte(8'h10, ak);
    check("R4 0x10 no hs", hs_mode, 0);
    bus_stop();

    // R8 pattern not as first byte after idle START
    bus_start(1);
    send_byte(8'hA0, ak);
    send_byte(8'h08, ak);
    check("R8 second byte ignored", hs_mode, 0);
    bus_start(2);
    send_byte(8'h0A, ak);
    check("R8 after rstart ignored", hs_mode, 0);
    check("R8 after rstart nack", ak, 0);
    bus_stop();

    // R9 general call reset clears hs_mode
    bus_start(1);
    send_byte(8'h08, ak);
    check("R4 hs set before gc", hs_mode, 1);
    bus_start(2);
    send_byte(8'h00, ak);
    check("R9 gc addr ack", ak, 1);
    check("R9 hs kept after gc addr", hs_mode, 1);
    send_byte(8'h06, ak);
    check("R9 gc cmd ack", ak, 1);
    check("R9 gc reset clears", hs_mode, 0);
    bus_stop();

    // R9 general call with another command is not acked
    bus_start(1);
    send_byte(8'h00, ak);
    check("R9 gc addr ack idle", ak, 1);
    send_byte(8'h04, ak);
    check("R9 other cmd nack", ak, 0);
    bus_stop();

    // R10 software reset
    bus_start(1);
    send_byte(8'h08, ak);
    check("R4 hs set before sw_rst", hs_mode, 1);
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    @(negedge clk);
    check("R10 sw_rst clears", hs_mode, 0);
    bus_stop();

    wq(2);
    check("R1 R2 R3 all events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule